// File: doc/BRIEF.md
# Buffered PWM Channel Counter

One pulse-width modulation channel built around an 8-bit counter. Software programs a duty value, a period value and three control bits (enable, polarity, alignment) over a small register bus. Duty and period land first in buffer registers. Active copies that drive the comparison take new values only when the counter is written, when a period ends, or while the channel is disabled. This keeps every running cycle self-consistent.

The counter advances only on system clock cycles where the prescaled tick input is high. In left-aligned mode it counts up from 0 to period-1 and wraps. In center-aligned mode it climbs to the period value and descends back to zero. The output pin is derived from the count, the direction, the active duty value and the polarity bit. A write of any value to the counter address restarts the waveform at once. Clearing the enable bit freezes the count, so the waveform resumes where it stopped.

Top module: `pwm_chan_top`

## Requirements
- R1: After reset, all four bus addresses read 0, the count is 0 and pwm_o is 1.
- R2: Presenting any address on the bus (bus_wr_i low) never changes the count.
- R3: A bus write of any data to address 3 (counter) sets the count to 0 and the direction to up on the next clock. The same write copies the duty and period buffers into the active copies. Provided the new active duty is nonzero, pwm_o then equals the polarity bit.
- R4: While enable (address 0 bit 0) is 0, ticks do not change a nonzero count. After enable returns to 1, the next tick advances the count from the held value.
- R5: While disabled, once the period buffer (address 2) holds 0, the next tick clears the count to 0.
- R6: With alignment (address 0 bit 2) at 0, the count runs 0,1,...,P-1,0 on successive ticks. In that mode pwm_o equals polarity (address 0 bit 1) while count < D, and its inverse otherwise. P is the active period and D is the active duty.
- R7: With alignment at 1, the count runs up 0..P-1, then holds P and steps down through P-1..1, then returns to 0, for 2*P ticks per period. pwm_o equals polarity while counting up with count < D, or while counting down with count <= D, and equals its inverse otherwise.
- R8: While enabled with active period 0, the count stays at 0. pwm_o is then constant: polarity when the active duty is nonzero, and its inverse when it is zero.
- R9: A duty or period write (address 1 or 2) while enabled is readable at once, but it does not change the waveform until the current period ends or the counter is written.
- R10: The count changes only on clock cycles with tick_i high, apart from counter writes.
- R11: Address 0 holds {align, polarity, enable} in bits 2..0. Address 1 holds the duty buffer, address 2 the period buffer, address 3 the live count. Each reads back what was written, except address 3, which reads the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | Prescaled clock enable; one count step per high cycle |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address (0 control, 1 duty, 2 period, 3 counter) |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i, combinational |
| pwm_o | output | 1 | PWM output pin |

## Verification
The assertions assume the active period stays fixed within a period. This holds because period writes reach the active copy only at the defined load points. The assertions also assume the counter stays at or below the active period, which holds as long as alignment changes only while the count is at zero. The stimulus changes alignment only while the channel is disabled and immediately follows that change with a counter write. It holds tick_i high for single cycles, never in the same cycle as a bus write.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;

  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_DUTY = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_PER  = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_CNT  = 2'd3;

  localparam int unsigned CTRL_EN_BIT  = 0;
  localparam int unsigned CTRL_POL_BIT = 1;
  localparam int unsigned CTRL_ALN_BIT = 2;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } cnt_dir_e;

  typedef struct packed {
    logic align;
    logic pol;
    logic en;
  } chan_ctrl_t;

endpackage

// File: rtl/pwm_chan_regs.sv
module pwm_chan_regs
  import pwm_chan_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [CNT_W-1:0]     wdata_i,
  input  logic [CNT_W-1:0]     cnt_i,
  output chan_ctrl_t           ctrl_o,
  output logic [CNT_W-1:0]     duty_buf_o,
  output logic [CNT_W-1:0]     per_buf_o,
  output logic                 cnt_wr_o,
  output logic [CNT_W-1:0]     rdata_o
);

  chan_ctrl_t            ctrl_q, ctrl_d;
  logic [CNT_W-1:0]      duty_q, duty_d;
  logic [CNT_W-1:0]      per_q, per_d;
  logic                  sel_ctrl, sel_duty, sel_per, sel_cnt;

  assign sel_ctrl = wr_i && (addr_i == ADDR_CTRL);
  assign sel_duty = wr_i && (addr_i == ADDR_DUTY);
  assign sel_per  = wr_i && (addr_i == ADDR_PER);
  assign sel_cnt  = wr_i && (addr_i == ADDR_CNT);

  always_comb begin
    ctrl_d = ctrl_q;
    duty_d = duty_q;
    per_d  = per_q;
    if (sel_ctrl) begin
      ctrl_d.en    = wdata_i[CTRL_EN_BIT];
      ctrl_d.pol   = wdata_i[CTRL_POL_BIT];
      ctrl_d.align = wdata_i[CTRL_ALN_BIT];
    end
    if (sel_duty) duty_d = wdata_i;
    if (sel_per)  per_d  = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      duty_q <= '0;
      per_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      duty_q <= duty_d;
      per_q  <= per_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_CTRL: begin
        rdata_o[CTRL_EN_BIT]  = ctrl_q.en;
        rdata_o[CTRL_POL_BIT] = ctrl_q.pol;
        rdata_o[CTRL_ALN_BIT] = ctrl_q.align;
      end
      ADDR_DUTY: rdata_o = duty_q;
      ADDR_PER:  rdata_o = per_q;
      default:   rdata_o = cnt_i;
    endcase
  end

  assign ctrl_o     = ctrl_q;
  assign duty_buf_o = duty_q;
  assign per_buf_o  = per_q;
  assign cnt_wr_o   = sel_cnt;

  // R11
  duty_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_duty |=> duty_q == $past(wdata_i));

  // R11
  per_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_per |=> per_q == $past(wdata_i));

endmodule

// File: rtl/pwm_chan_counter.sv
module pwm_chan_counter
  import pwm_chan_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_i,
  input  logic                 en_i,
  input  logic                 align_i,
  input  logic                 cnt_wr_i,
  input  logic [CNT_W-1:0]     duty_buf_i,
  input  logic [CNT_W-1:0]     per_buf_i,
  output logic [CNT_W-1:0]     cnt_o,
  output cnt_dir_e             dir_o,
  output logic [CNT_W-1:0]     duty_act_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  cnt_dir_e         dir_q, dir_d;
  logic [CNT_W-1:0] duty_act_q, duty_act_d;
  logic [CNT_W-1:0] per_act_q, per_act_d;
  logic [CNT_W-1:0] per_m1;
  logic             per_zero;
  logic             load;

  assign per_zero = (per_act_q == '0);
  assign per_m1   = per_act_q - ONE;

  always_comb begin
    cnt_d = cnt_q;
    dir_d = dir_q;
    load  = 1'b0;
    if (cnt_wr_i) begin
      cnt_d = '0;
      dir_d = DIR_UP;
      load  = 1'b1;
    end else if (!en_i) begin
      load = 1'b1;
      if (tick_i && (per_buf_i == '0)) begin
        cnt_d = '0;
        dir_d = DIR_UP;
      end
    end else if (tick_i) begin
      if (per_zero) begin
        cnt_d = '0;
        dir_d = DIR_UP;
        load  = 1'b1;
      end else if (!align_i) begin
        dir_d = DIR_UP;
        if (cnt_q >= per_m1) begin
          cnt_d = '0;
          load  = 1'b1;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end else if (dir_q == DIR_UP) begin
        if (cnt_q >= per_m1) begin
          cnt_d = per_act_q;
          dir_d = DIR_DOWN;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end else begin
        if (cnt_q <= ONE) begin
          cnt_d = '0;
          dir_d = DIR_UP;
          load  = 1'b1;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
    end
  end

  always_comb begin
    duty_act_d = duty_act_q;
    per_act_d  = per_act_q;
    if (load) begin
      duty_act_d = duty_buf_i;
      per_act_d  = per_buf_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      dir_q      <= DIR_UP;
      duty_act_q <= '0;
      per_act_q  <= '0;
    end else begin
      cnt_q      <= cnt_d;
      dir_q      <= dir_d;
      duty_act_q <= duty_act_d;
      per_act_q  <= per_act_d;
    end
  end

  assign cnt_o      = cnt_q;
  assign dir_o      = dir_q;
  assign duty_act_o = duty_act_q;

  // R3
  cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_i |=> (cnt_q == '0) && (dir_q == DIR_UP) && (per_act_q == $past(per_buf_i)));

  // R4
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !cnt_wr_i && (per_buf_i != '0)) |=> $stable(cnt_q));

  // R10
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !cnt_wr_i) |=> $stable(cnt_q));

  // R8
  zero_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && tick_i && !cnt_wr_i && per_zero) |=> (cnt_q == '0));

  // R7
  center_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && align_i && !cnt_wr_i && !per_zero && (cnt_q <= per_act_q))
      |=> (cnt_q <= $past(per_act_q)));

  // R6
  left_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && tick_i && !align_i && !cnt_wr_i && !per_zero && (cnt_q < per_m1))
      |=> (cnt_q == $past(cnt_q) + ONE));

endmodule

// File: rtl/pwm_chan_outgen.sv
module pwm_chan_outgen
  import pwm_chan_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  cnt_dir_e         dir_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic             align_i,
  input  logic             pol_i,
  output logic             pwm_o
);

  logic below_up;
  logic below_dn;
  logic active;

  assign below_up = (cnt_i < duty_i);
  assign below_dn = (cnt_i <= duty_i);

  always_comb begin
    if (!align_i || (dir_i == DIR_UP)) active = below_up;
    else                               active = below_dn;
  end

  assign pwm_o = active ? pol_i : ~pol_i;

endmodule

// File: rtl/pwm_chan_top.sv
module pwm_chan_top
  import pwm_chan_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             bus_wr_i,
  input  logic [1:0]       bus_addr_i,
  input  logic [CNT_W-1:0] bus_wdata_i,
  output logic [CNT_W-1:0] bus_rdata_o,
  output logic             pwm_o
);

  logic             rst_meta_q;
  logic             rst_sync_q;
  chan_ctrl_t       ctrl;
  logic [CNT_W-1:0] duty_buf;
  logic [CNT_W-1:0] per_buf;
  logic             cnt_wr;
  logic [CNT_W-1:0] cnt;
  cnt_dir_e         dir;
  logic [CNT_W-1:0] duty_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  pwm_chan_regs #(.CNT_W(CNT_W)) regs_i (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .wr_i       (bus_wr_i),
    .addr_i     (bus_addr_i),
    .wdata_i    (bus_wdata_i),
    .cnt_i      (cnt),
    .ctrl_o     (ctrl),
    .duty_buf_o (duty_buf),
    .per_buf_o  (per_buf),
    .cnt_wr_o   (cnt_wr),
    .rdata_o    (bus_rdata_o)
  );

  pwm_chan_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .tick_i     (tick_i),
    .en_i       (ctrl.en),
    .align_i    (ctrl.align),
    .cnt_wr_i   (cnt_wr),
    .duty_buf_i (duty_buf),
    .per_buf_i  (per_buf),
    .cnt_o      (cnt),
    .dir_o      (dir),
    .duty_act_o (duty_act)
  );

  pwm_chan_outgen #(.CNT_W(CNT_W)) out_i (
    .cnt_i   (cnt),
    .dir_i   (dir),
    .duty_i  (duty_act),
    .align_i (ctrl.align),
    .pol_i   (ctrl.pol),
    .pwm_o   (pwm_o)
  );

  // R3
  restart_pin_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (cnt_wr && (duty_buf != '0)) |=> (pwm_o == ctrl.pol));

endmodule

// File: tb/pwm_chan_top_tb_top.sv
module pwm_chan_top_tb_top;

  logic       clk;
  logic       rst_n;
  logic       tick_i;
  logic       bus_wr_i;
  logic [1:0] bus_addr_i;
  logic [7:0] bus_wdata_i;
  logic [7:0] bus_rdata_o;
  logic       pwm_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  pwm_chan_top #(.CNT_W(8)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .pwm_o       (pwm_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int exp, input string what);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk);
    bus_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    bus_addr_i = a;
    #1;
    v = bus_rdata_o;
  endtask

  task automatic tick();
    @(negedge clk);
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic chk_cnt(input string req, input int exp, input string what);
    logic [7:0] v;
    rd(2'd3, v);
    check(req, v, exp, what);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      check("R1", v, 0, "reset register value");
    end
    check("R1", pwm_o, 1, "reset pin level");
  endtask

  task automatic t_regmap();
    logic [7:0] v;
    wr(2'd0, 8'h02);
    wr(2'd1, 8'd2);
    wr(2'd2, 8'd4);
    rd(2'd0, v); check("R11", v, 2, "control readback");
    rd(2'd1, v); check("R11", v, 2, "duty readback");
    rd(2'd2, v); check("R11", v, 4, "period readback");
  endtask

  task automatic t_left();
    wr(2'd0, 8'h03);
    wr(2'd3, 8'hA7);
    for (int i = 0; i < 8; i++) begin
      chk_cnt("R6", i % 4, "left count");
      check("R6", pwm_o, ((i % 4) < 2) ? 1 : 0, "left pin");
      tick();
    end
  endtask

  task automatic t_cntwr();
    tick(); tick();
    chk_cnt("R3", 2, "count before restart");
    check("R3", pwm_o, 0, "pin before restart");
    wr(2'd3, 8'h55);
    chk_cnt("R3", 0, "count after restart");
    check("R3", pwm_o, 1, "pin after restart");
  endtask

  task automatic t_notick();
    logic [7:0] v;
    tick();
    chk_cnt("R10", 1, "count after one tick");
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      rd(i[1:0], v);
    end
    chk_cnt("R10", 1, "count across idle clocks");
    chk_cnt("R2", 1, "count after reads");
  endtask

  task automatic t_buffer();
    logic [7:0] v;
    wr(2'd3, 8'h00);
    wr(2'd1, 8'd4);
    rd(2'd1, v); check("R9", v, 4, "duty buffer readback");
    tick(); tick();
    chk_cnt("R9", 2, "count mid period");
    check("R9", pwm_o, 0, "old duty still active");
    tick(); tick();
    chk_cnt("R9", 0, "wrapped");
    tick(); tick();
    check("R9", pwm_o, 1, "new duty after period end");
    wr(2'd1, 8'd2);
    wr(2'd3, 8'h00);
  endtask

  task automatic t_disable();
    tick(); tick();
    wr(2'd0, 8'h02);
    tick(); tick(); tick();
    chk_cnt("R4", 2, "count frozen");
    wr(2'd0, 8'h03);
    tick();
    chk_cnt("R4", 3, "resumed from held count");
    tick();
    chk_cnt("R4", 0, "wrap after resume");
  endtask

  task automatic t_per_zero_off();
    tick(); tick();
    wr(2'd0, 8'h02);
    wr(2'd2, 8'd0);
    chk_cnt("R5", 2, "count before tick");
    tick();
    chk_cnt("R5", 0, "cleared on next tick");
  endtask

  task automatic t_per_zero_on();
    wr(2'd0, 8'h03);
    for (int i = 0; i < 3; i++) begin
      tick();
      chk_cnt("R8", 0, "count pinned at zero");
      check("R8", pwm_o, 1, "pin with nonzero duty");
    end
    wr(2'd1, 8'd0);
    tick();
    chk_cnt("R8", 0, "count pinned at zero");
    check("R8", pwm_o, 0, "pin with zero duty");
  endtask

  task automatic t_center();
    int ec;
    bit up;
    wr(2'd0, 8'h02);
    wr(2'd1, 8'd1);
    wr(2'd2, 8'd3);
    wr(2'd0, 8'h07);
    wr(2'd3, 8'h00);
    for (int k = 0; k < 12; k++) begin
      int ph;
      ph = k % 6;
      up = (ph < 3);
      ec = (ph <= 3) ? ph : 6 - ph;
      chk_cnt("R7", ec, "center count");
      check("R7", pwm_o, (up ? (ec < 1) : (ec <= 1)) ? 1 : 0, "center pin");
      tick();
    end
  endtask

  initial begin
    rst_n = 1'b0; tick_i = 1'b0; bus_wr_i = 1'b0;
    bus_addr_i = 2'd0; bus_wdata_i = 8'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_regmap();
    t_left();
    t_cntwr();
    t_notick();
    t_buffer();
    t_disable();
    t_per_zero_off();
    t_per_zero_on();
    t_center();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fails++;
      $display("FAIL R1-watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule